// File: doc/BRIEF.md
# Octal Driver SPI Frame Controller

This block is the serial slave front end of an eight-channel output driver. A host lowers the slave select, clocks a command frame in on `mosi` and, during the same transfer, receives a status frame on `miso`. When slave select rises, the block checks the frame. If the frame is good, the eight channel enables take the received command. The `frame16` input picks between two formats. The short format is one byte of channel enables. The long format is 16 bits: the enables, then four bits that are ignored, then a four-bit protection code.

All serial pins are sampled by the block clock, and one register stage is used to detect edges on them. Data moves most significant bit first. On a rising edge of `sclk` the block samples `mosi`. On a falling edge the shift register advances, and the sampled bit enters at its low end. A frame longer than one frame size therefore leaves `miso` carrying the bits the host sent one frame earlier. This lets several devices be chained. Per-channel overtemperature events are held in a latch until the end of the next transfer. A non-latched, active-low `fault_n` reports any live overtemperature or a rejected last frame.

The control machine has three states. It moves from IDLE to XFER on a falling edge of slave select; on this transition it loads the status frame and samples `frame16`. It moves from XFER to COMMIT on a rising edge of slave select. It moves from COMMIT back to IDLE unconditionally after one cycle, and it judges the frame during that cycle. `miso_oe` is high only in XFER. The host must leave at least two block clocks between the rise of slave select and the next fall.

Top module: `octdrv_spi_ctl`

## Requirements
- R1: In the short format, the last eight bits received become `ch_en`, with the first of them in bit 7 and the last in bit 0; a 1 enables the channel. `ch_en` changes only in the COMMIT cycle after a frame that passed every check. It resets to 0.
- R2: In the long format, the command word (the last 16 bits received) holds the enables in bits 15..8. Bits 3..0 are the code {P2,P1,P0,nP0}: P0 is the XOR of all eight enables, P1 is the XOR of enables 1, 3, 5 and 7, P2 is the XOR of enables 0, 2, 4 and 6, and nP0 = ~P0. A mismatch rejects the frame, and the enables keep their previous value.
- R3: A frame is accepted only when its count of `sclk` rising edges is a nonzero multiple of the frame size (8 or 16). Any other count, including zero, rejects the frame. When a frame is longer than one frame size, the last frame-size bits are used.
- R4: The short status frame sends the latched overtemperature flags, channel 7 first. A flag reads 1 if `ovt_in` for that channel was high at any clock since the last COMMIT, up to and including the cycle in which slave select falls.
- R5: The long status frame sends, from first to last: flags 7..0, FB_OK, the `temp_warn` level, PC, the `supply_good` level, P2, P1, P0, nP0. Here P0 is the XOR of the flags, P1 is the XOR of PC, FB_OK and flags 1, 3, 5, 7, P2 is the XOR of the supply-good bit, the warning bit and flags 0, 2, 4, 6, and nP0 = ~P0. PC is 1 when the previous frame was rejected.
- R6: The latched flags are kept until the COMMIT cycle of every transfer, valid or not. At that point they reload from the current `ovt_in`.
- R7: `fault_n` is low whenever any `ovt_in` bit is high or the last frame was rejected. It is high otherwise, so an accepted frame releases the frame part of the fault. It is high after reset.
- R8: FB_OK is 0 after reset. It becomes 1 at the COMMIT of an accepted frame while `fb_good` is high, and it returns to 0 on the clock after `fb_good` falls.
- R9: `miso_oe` is high only while a transfer is open (XFER), and `miso` is 0 otherwise. Once a full status frame has been sent, `miso` repeats the bits received, delayed by one frame size.
- R10: The four bits between the enables and the code in a long command have no effect on `ch_en` or on acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame16 | input | 1 | 1 selects the 16-bit format, sampled when slave select falls |
| ss_n | input | 1 | Active-low slave select |
| sclk | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Drive enable for `miso` |
| ovt_in | input | 8 | Live per-channel overtemperature levels |
| temp_warn | input | 1 | Case temperature warning level |
| supply_good | input | 1 | Supply-good level |
| fb_good | input | 1 | Regulator feedback-good level |
| ch_en | output | 8 | Channel enables |
| fault_n | output | 1 | Common fault, active low |

## Verification
The assertions check on every cycle that `ch_en` moves only in COMMIT, that the latched flags never drop outside COMMIT, that a rejected length always sets PC, that an accepted frame with no live overtemperature releases `fault_n`, that FB_OK clears when feedback drops, and that the output is quiet while slave select stays high. The exact bit order and parity of both status formats, the placement of the command bits, the ignoring of the gap bits, and the daisy-chain echo on `miso` can only be shown by the bench's transfers. The bench compares those against a queue model of the wire.

// File: rtl/octdrv_pkg.sv
package octdrv_pkg;
    localparam int NCH     = 8;
    localparam int SHORT_W = 8;
    localparam int LONG_W  = 16;
    localparam int CODE_W  = 4;
    localparam int CNT_W   = $clog2(LONG_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_COMMIT
    } link_state_t;

    // protection code carried by a long command: {P2, P1, P0, nP0}
    function automatic logic [CODE_W-1:0] cmd_code(input logic [NCH-1:0] d);
        logic p0, p1, p2;
        p0 = ^d;
        p1 = d[1] ^ d[3] ^ d[5] ^ d[7];
        p2 = d[0] ^ d[2] ^ d[4] ^ d[6];
        return {p2, p1, p0, ~p0};
    endfunction

    // protection code carried by a long status frame
    function automatic logic [CODE_W-1:0] stat_code(input logic [NCH-1:0] f,
                                                    input logic fbok,
                                                    input logic tw,
                                                    input logic pc,
                                                    input logic pg);
        logic p0, p1, p2;
        p0 = ^f;
        p1 = pc ^ fbok ^ f[1] ^ f[3] ^ f[5] ^ f[7];
        p2 = pg ^ tw ^ f[0] ^ f[2] ^ f[4] ^ f[6];
        return {p2, p1, p0, ~p0};
    endfunction
endpackage

// File: rtl/octdrv_shreg.sv
module octdrv_shreg
    import octdrv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LONG_W-1:0] load_val,
    input  logic              active,
    input  logic              mode16,
    input  logic              rise,
    input  logic              fall,
    input  logic              mosi,
    output logic [LONG_W-1:0] sr,
    output logic              miso_bit,
    output logic              len_ok
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_idx;
    logic             seen;
    logic             mosi_s;

    assign last_idx = mode16 ? CNT_W'(LONG_W - 1) : CNT_W'(SHORT_W - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            seen   <= 1'b0;
            mosi_s <= 1'b0;
        end else if (load) begin
            cnt    <= '0;
            seen   <= 1'b0;
        end else if (active && rise) begin
            mosi_s <= mosi;
            seen   <= 1'b1;
            cnt    <= (cnt == last_idx) ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr <= '0;
        else if (load)
            sr <= load_val;
        else if (active && fall)
            sr <= {sr[LONG_W-2:0], mosi_s};
    end

    assign miso_bit = mode16 ? sr[LONG_W-1] : sr[SHORT_W-1];
    assign len_ok   = seen && (cnt == '0);

    // R3: the edge count never leaves the range of the short frame in short mode
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode16) |-> (cnt < CNT_W'(SHORT_W)));
endmodule

// File: rtl/octdrv_frame_chk.sv
module octdrv_frame_chk
    import octdrv_pkg::*;
(
    input  logic              mode16,
    input  logic              len_ok,
    input  logic [LONG_W-1:0] sr,
    output logic [NCH-1:0]    cmd,
    output logic              frame_ok
);
    logic code_ok;

    assign cmd     = mode16 ? sr[LONG_W-1 -: NCH] : sr[NCH-1:0];
    assign code_ok = !mode16 || (sr[CODE_W-1:0] == cmd_code(sr[LONG_W-1 -: NCH]));
    assign frame_ok = len_ok && code_ok;
endmodule

// File: rtl/octdrv_ctl.sv
module octdrv_ctl
    import octdrv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_fall,
    input  logic              ss_rise,
    input  logic              frame16,
    input  logic              frame_ok,
    input  logic              len_ok,
    input  logic [NCH-1:0]    cmd,
    input  logic [NCH-1:0]    ovt_in,
    input  logic              temp_warn,
    input  logic              supply_good,
    input  logic              fb_good,
    output logic              load,
    output logic [LONG_W-1:0] load_val,
    output logic              active,
    output logic              commit,
    output logic              mode_q,
    output logic [NCH-1:0]    ch_en,
    output logic              pc_err
);
    link_state_t    state, state_nx;
    logic [NCH-1:0] ovt_lat;
    logic [NCH-1:0] snap;
    logic           fb_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        active   = 1'b0;
        commit   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ss_fall) begin
                    load     = 1'b1;
                    state_nx = ST_XFER;
                end
            end
            ST_XFER: begin
                active = 1'b1;
                if (ss_rise)
                    state_nx = ST_COMMIT;
            end
            ST_COMMIT: begin
                commit   = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign snap = ovt_lat | ovt_in;

    always_comb begin
        if (frame16)
            load_val = {snap, fb_ok, temp_warn, pc_err, supply_good,
                        stat_code(snap, fb_ok, temp_warn, pc_err, supply_good)};
        else
            load_val = {{(LONG_W-NCH){1'b0}}, snap};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovt_lat <= '0;
            ch_en   <= '0;
            pc_err  <= 1'b0;
            fb_ok   <= 1'b0;
            mode_q  <= 1'b0;
        end else begin
            ovt_lat <= commit ? ovt_in : snap;
            if (load)
                mode_q <= frame16;
            if (commit) begin
                pc_err <= ~frame_ok;
                if (frame_ok)
                    ch_en <= cmd;
            end
            if (!fb_good)
                fb_ok <= 1'b0;
            else if (commit && frame_ok)
                fb_ok <= 1'b1;
        end
    end

    // R1: enables move only while judging a frame
    p_chen_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COMMIT) |=> $stable(ch_en));

    // R3: a frame of wrong length always reports a parity/length error
    p_len_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !len_ok) |=> pc_err);

    // R6: latched flags never drop outside the commit cycle
    p_lat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COMMIT) |=> ((ovt_lat & $past(ovt_lat)) == $past(ovt_lat)));

    // R8: feedback loss clears the good bit on the next clock
    p_fbok_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fb_good) |=> !fb_ok);
endmodule

// File: rtl/octdrv_spi_ctl.sv
module octdrv_spi_ctl
    import octdrv_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame16,
    input  logic           ss_n,
    input  logic           sclk,
    input  logic           mosi,
    output logic           miso,
    output logic           miso_oe,
    input  logic [NCH-1:0] ovt_in,
    input  logic           temp_warn,
    input  logic           supply_good,
    input  logic           fb_good,
    output logic [NCH-1:0] ch_en,
    output logic           fault_n
);
    logic              ss_q, sclk_q;
    logic              ss_fall, ss_rise, sck_rise, sck_fall;
    logic              load, active, commit, mode_q, pc_err;
    logic              len_ok, frame_ok, miso_bit;
    logic [LONG_W-1:0] load_val, sr;
    logic [NCH-1:0]    cmd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            ss_q   <= ss_n;
            sclk_q <= sclk;
        end
    end

    assign ss_fall  = ss_q & ~ss_n;
    assign ss_rise  = ~ss_q & ss_n;
    assign sck_rise = sclk & ~sclk_q;
    assign sck_fall = ~sclk & sclk_q;

    octdrv_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .ss_fall(ss_fall), .ss_rise(ss_rise),
        .frame16(frame16), .frame_ok(frame_ok), .len_ok(len_ok), .cmd(cmd),
        .ovt_in(ovt_in), .temp_warn(temp_warn), .supply_good(supply_good),
        .fb_good(fb_good), .load(load), .load_val(load_val), .active(active),
        .commit(commit), .mode_q(mode_q), .ch_en(ch_en), .pc_err(pc_err)
    );

    octdrv_shreg u_shreg (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .active(active), .mode16(mode_q), .rise(sck_rise), .fall(sck_fall),
        .mosi(mosi), .sr(sr), .miso_bit(miso_bit), .len_ok(len_ok)
    );

    octdrv_frame_chk u_chk (
        .mode16(mode_q), .len_ok(len_ok), .sr(sr), .cmd(cmd), .frame_ok(frame_ok)
    );

    assign miso_oe = active;
    assign miso    = active & miso_bit;
    assign fault_n = ~((|ovt_in) | pc_err);

    // R9: output stays quiet while slave select is held high
    p_oe_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_n && $past(ss_n)) |-> !miso_oe);

    // R7: an accepted frame releases the fault unless a channel is hot
    p_fault_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frame_ok) |=> (fault_n || (|ovt_in)));
endmodule

// File: tb/sim_octdrv_spi_ctl.sv
module sim_octdrv_spi_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame16 = 1'b0, ss_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic       miso, miso_oe;
    logic [7:0] ovt_in = 8'h00;
    logic       temp_warn = 1'b0, supply_good = 1'b0, fb_good = 1'b0;
    logic [7:0] ch_en;
    logic       fault_n;

    int  n_chk = 0, n_fail = 0;
    bit  live = 1'b0;

    // reference state
    logic [7:0] m_ch = 8'h00, m_lat = 8'h00;
    logic       m_pc = 1'b0, m_fbok = 1'b0;

    always #4 clk = ~clk;

    octdrv_spi_ctl u0 (
        .clk(clk), .rst_n(rst_n), .frame16(frame16), .ss_n(ss_n), .sclk(sclk),
        .mosi(mosi), .miso(miso), .miso_oe(miso_oe), .ovt_in(ovt_in),
        .temp_warn(temp_warn), .supply_good(supply_good), .fb_good(fb_good),
        .ch_en(ch_en), .fault_n(fault_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // compared on every clock
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (live) begin
                chk(ch_en === m_ch, "R1 ch_en", {24'h0, ch_en}, {24'h0, m_ch});
                chk(fault_n === ~((|ovt_in) | m_pc), "R7 fault_n",
                    {31'h0, fault_n}, {31'h0, ~((|ovt_in) | m_pc)});
            end
        end
    end

    task automatic set_ovt(input logic [7:0] v);
        @(negedge clk);
        ovt_in = v;
        m_lat  = m_lat | v;
    endtask

    task automatic set_fb(input logic v);
        @(negedge clk);
        fb_good = v;
        if (!v) m_fbok = 1'b0;
    endtask

    function automatic logic [15:0] mk16(input logic [7:0] c, input logic [3:0] gap);
        logic p0;
        p0 = ^c;
        return {c, gap, c[0]^c[2]^c[4]^c[6], c[1]^c[3]^c[5]^c[7], p0, ~p0};
    endfunction

    task automatic xfer(input bit m16, input int nb, input logic [31:0] dat,
                        input string req);
        logic       q[$];
        logic [7:0] snap, c;
        logic [15:0] sw, w;
        logic       p0, exp_b, ok;
        int         fw;
        @(negedge clk);
        frame16 = m16;
        ss_n    = 1'b0;
        snap    = m_lat | ovt_in;
        p0      = ^snap;
        if (m16) begin
            sw = {snap, m_fbok, temp_warn, m_pc, supply_good,
                  supply_good ^ temp_warn ^ snap[0] ^ snap[2] ^ snap[4] ^ snap[6],
                  m_pc ^ m_fbok ^ snap[1] ^ snap[3] ^ snap[5] ^ snap[7], p0, ~p0};
            for (int i = 15; i >= 0; i--) q.push_back(sw[i]);
        end else begin
            for (int i = 7; i >= 0; i--) q.push_back(snap[i]);
        end
        @(negedge clk);
        chk(miso_oe === 1'b1, "R9 oe open", {31'h0, miso_oe}, 32'h1);
        for (int i = 0; i < nb; i++) begin
            mosi  = dat[nb-1-i];
            exp_b = q.pop_front();
            chk(miso === exp_b, req, {31'h0, miso}, {31'h0, exp_b});
            q.push_back(dat[nb-1-i]);
            @(negedge clk); sclk = 1'b1;
            @(negedge clk); sclk = 1'b0;
            @(negedge clk);
        end
        ss_n = 1'b1;
        fw = m16 ? 16 : 8;
        ok = (nb > 0) && (nb % fw == 0);
        w  = dat[15:0];
        if (m16) begin
            c  = w[15:8];
            ok = ok && (w[0] == ~(^c)) && (w[1] == ^c) &&
                 (w[2] == (c[1]^c[3]^c[5]^c[7])) && (w[3] == (c[0]^c[2]^c[4]^c[6]));
        end else begin
            c = w[7:0];
        end
        @(posedge clk);
        @(posedge clk);
        m_lat = ovt_in;
        m_pc  = ~ok;
        if (ok) m_ch = c;
        if (ok && fb_good) m_fbok = 1'b1;
        @(negedge clk);
        chk(miso_oe === 1'b0 && miso === 1'b0, "R9 oe closed", {30'h0, miso_oe, miso}, 32'h0);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ch_en === 8'h00, "R1 reset enables", {24'h0, ch_en}, 32'h0);
        chk(fault_n === 1'b1, "R7 reset fault", {31'h0, fault_n}, 32'h1);
        chk(miso_oe === 1'b0, "R9 reset oe", {31'h0, miso_oe}, 32'h0);
        live = 1'b1;

        // R1: short command mapping
        xfer(1'b0, 8, 32'hA5, "R4 status short");
        chk(ch_en === 8'hA5, "R1 short cmd", {24'h0, ch_en}, 32'hA5);

        // R4, R6: latched flags survive the event and clear after the next frame
        set_ovt(8'h12);
        repeat (3) @(negedge clk);
        chk(fault_n === 1'b0, "R7 live ovt", {31'h0, fault_n}, 32'h0);
        set_ovt(8'h00);
        xfer(1'b0, 8, 32'h3C, "R4 R6 latched flags");
        xfer(1'b0, 8, 32'h3C, "R6 flags cleared");

        // R2, R5, R8, R10: long frame with nonzero gap bits
        temp_warn = 1'b1; supply_good = 1'b1;
        set_fb(1'b1);
        xfer(1'b1, 16, {16'h0, mk16(8'hC3, 4'hB)}, "R5 status long");
        chk(ch_en === 8'hC3, "R10 gap ignored", {24'h0, ch_en}, 32'hC3);
        xfer(1'b1, 16, {16'h0, mk16(8'h5A, 4'h0)}, "R8 fb_ok set");

        // R2: bad code keeps enables and raises fault
        xfer(1'b1, 16, {16'h0, mk16(8'h0F, 4'h0) ^ 16'h0002}, "R5 long");
        chk(ch_en === 8'h5A, "R2 bad code kept", {24'h0, ch_en}, 32'h5A);
        chk(fault_n === 1'b0, "R7 bad frame fault", {31'h0, fault_n}, 32'h0);
        xfer(1'b1, 16, {16'h0, mk16(8'h81, 4'h6)}, "R5 pc reported");
        chk(fault_n === 1'b1, "R7 released", {31'h0, fault_n}, 32'h1);

        // R3: wrong lengths
        xfer(1'b0, 12, 32'h0FFF, "R3 short odd length");
        chk(ch_en === 8'h81, "R3 12 bits rejected", {24'h0, ch_en}, 32'h81);
        xfer(1'b1, 20, {12'h0, mk16(8'h44, 4'h0), 4'h0}, "R3 long odd length");
        chk(ch_en === 8'h81, "R3 20 bits rejected", {24'h0, ch_en}, 32'h81);
        xfer(1'b0, 0, 32'h0, "R3 zero length");
        chk(fault_n === 1'b0, "R3 zero length fault", {31'h0, fault_n}, 32'h0);

        // R3, R9: chained frames echo the earlier bits
        xfer(1'b0, 16, 32'h96E7, "R9 short chain echo");
        chk(ch_en === 8'hE7, "R3 short chain", {24'h0, ch_en}, 32'hE7);
        xfer(1'b1, 32, {mk16(8'h33, 4'h9), mk16(8'h6C, 4'h2)}, "R9 long chain echo");
        chk(ch_en === 8'h6C, "R3 long chain", {24'h0, ch_en}, 32'h6C);

        // R8: feedback loss
        set_fb(1'b0);
        supply_good = 1'b0;
        set_ovt(8'h80);
        xfer(1'b1, 16, {16'h0, mk16(8'h01, 4'h0)}, "R8 fb_ok cleared");
        set_ovt(8'h00);
        xfer(1'b1, 16, {16'h0, mk16(8'h02, 4'h0)}, "R5 after drop");
        chk(ch_en === 8'h02, "R2 long cmd", {24'h0, ch_en}, 32'h02);

        live = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule